// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Interlock Unit

This block watches the register traffic of a five-stage in-order pipeline and decides, each cycle, where the two ALU operands of the instruction in the execute stage come from. An operand can come from the register file value read in decode, from the result held in the execute/memory pipeline register, or from the result held in the memory/writeback pipeline register. When both later stages hold a matching result, the younger one (execute/memory) wins, because it is the more recent write to that register.

Forwarding covers every producer/consumer distance except one. A load delivers its data only at the end of its memory cycle, so an instruction that uses the loaded register directly after the load cannot be fed in time. The unit spots this by comparing the load's destination, while the load sits in execute, against both source fields of the instruction in decode. It then raises a hold for the program counter and the fetch/decode register, plus a clear for the control fields entering the decode/execute register. This inserts exactly one bubble, and after it the case is served by the memory/writeback path.

A producer three instructions ahead writes back while its consumer is in decode. The register file is expected to return the newly written value in that case (write-before-read), so the unit adds nothing for it. All outputs are combinational functions of the current inputs. The clock and reset only sample the embedded property checks.

Top module: `pipe_hazard_unit`

## Requirements
- R1: An operand whose source register equals a non-zero execute/memory destination with its write flag set gets select 2'b10 in the same cycle.
- R2: An operand that matches a non-zero, write-enabled memory/writeback destination, and does not match the execute/memory stage, gets select 2'b01.
- R3: When both stages match an operand, the select is 2'b10 (the execute/memory stage has priority).
- R4: A producer whose destination is register 0, or whose write flag is low, never causes forwarding. The select then falls through to the other stage or to 2'b00.
- R5: An operand that matches no later stage gets select 2'b00, meaning the register file value.
- R6: The two operand selects (A from the first source field, B from the second) are decided independently of each other.
- R7: When the execute-stage instruction is a load with a non-zero destination equal to either decode-stage source field, the PC hold, the fetch/decode hold and the decode/execute bubble are all 1 in that cycle.
- R8: The three stall outputs are 0 in every other case: a non-load producer, a load to register 0, or a load whose destination matches neither decode source. The three stall outputs always carry the same value.
- R9: The outputs follow input changes within the same cycle, with no register between inputs and outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the embedded property checks |
| rst | input | 1 | Synchronous active-high reset for the property checks |
| ex_src_a | input | AW | First source register of the instruction in execute |
| ex_src_b | input | AW | Second source register of the instruction in execute |
| mem_dst | input | AW | Destination register held in execute/memory |
| mem_wr | input | 1 | Register-write flag held in execute/memory |
| wb_dst | input | AW | Destination register held in memory/writeback |
| wb_wr | input | 1 | Register-write flag held in memory/writeback |
| ex_is_load | input | 1 | Instruction in execute is a load |
| ex_dst | input | AW | Destination register of the instruction in execute |
| id_src_a | input | AW | First source register of the instruction in decode |
| id_src_b | input | AW | Second source register of the instruction in decode |
| fwd_a | output | 2 | Operand A select: 00 register file, 10 execute/memory, 01 memory/writeback |
| fwd_b | output | 2 | Operand B select, same encoding |
| hold_pc | output | 1 | Keep the program counter unchanged |
| hold_ifid | output | 1 | Keep the fetch/decode register unchanged |
| bubble_idex | output | 1 | Clear the control fields entering decode/execute |

## Verification
The hardest case to reach is the one where both later stages carry the same destination, which is also an operand's source, while one of those stages has its write flag low or targets register 0. This is the point where priority and the enable qualification interact. In a real pipeline it needs two back-to-back writers to the same register, with the younger one being a store or a branch. Because the unit has no internal state, the bench places those stage contents directly on the ports, one directed case per combination. It also checks the load-use detection against the second decode field alone, so a compare that only watches the first field is caught.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hz_src_match.sv
module hz_src_match #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] prod_dst,
  input  logic          prod_valid,
  output logic          hit
);
  // register 0 is hard-wired, so a write to it never yields a value
  always_comb begin
    hit = prod_valid && (prod_dst != '0) && (prod_dst == src);
  end
endmodule

// File: rtl/hz_fwd_select.sv
module hz_fwd_select
  import hz_pkg::*;
(
  input  logic     hit_mem,
  input  logic     hit_wb,
  output fwd_sel_e sel
);
  // younger stage first
  always_comb begin
    if (hit_mem)     sel = FWD_MEM;
    else if (hit_wb) sel = FWD_WB;
    else             sel = FWD_RF;
  end
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int AW = 5
) (
  input  logic          ex_is_load,
  input  logic [AW-1:0] ex_dst,
  input  logic [AW-1:0] id_src_a,
  input  logic [AW-1:0] id_src_b,
  output logic          stall
);
  logic hit_a, hit_b;

  hz_src_match #(.AW(AW)) u_cmp_a (
    .src(id_src_a), .prod_dst(ex_dst), .prod_valid(ex_is_load), .hit(hit_a)
  );
  hz_src_match #(.AW(AW)) u_cmp_b (
    .src(id_src_b), .prod_dst(ex_dst), .prod_valid(ex_is_load), .hit(hit_b)
  );

  always_comb begin
    stall = hit_a || hit_b;
  end
endmodule

// File: rtl/pipe_hazard_unit.sv
module pipe_hazard_unit
  import hz_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ex_src_a,
  input  logic [AW-1:0] ex_src_b,
  input  logic [AW-1:0] mem_dst,
  input  logic          mem_wr,
  input  logic [AW-1:0] wb_dst,
  input  logic          wb_wr,
  input  logic          ex_is_load,
  input  logic [AW-1:0] ex_dst,
  input  logic [AW-1:0] id_src_a,
  input  logic [AW-1:0] id_src_b,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          hold_pc,
  output logic          hold_ifid,
  output logic          bubble_idex
);
  localparam int NOPS = 2;

  logic [AW-1:0] op_src [NOPS];
  fwd_sel_e      op_sel [NOPS];
  logic          stall;

  always_comb begin
    op_src[0] = ex_src_a;
    op_src[1] = ex_src_b;
  end

  for (genvar k = 0; k < NOPS; k++) begin : g_op
    logic hit_mem, hit_wb;
    hz_src_match #(.AW(AW)) u_mem (
      .src(op_src[k]), .prod_dst(mem_dst), .prod_valid(mem_wr), .hit(hit_mem)
    );
    hz_src_match #(.AW(AW)) u_wb (
      .src(op_src[k]), .prod_dst(wb_dst), .prod_valid(wb_wr), .hit(hit_wb)
    );
    hz_fwd_select u_sel (.hit_mem(hit_mem), .hit_wb(hit_wb), .sel(op_sel[k]));
  end

  hz_load_use #(.AW(AW)) u_lu (
    .ex_is_load(ex_is_load), .ex_dst(ex_dst),
    .id_src_a(id_src_a), .id_src_b(id_src_b), .stall(stall)
  );

  always_comb begin
    fwd_a       = op_sel[0];
    fwd_b       = op_sel[1];
    hold_pc     = stall;
    hold_ifid   = stall;
    bubble_idex = stall;
  end

  // R1 / R3: a live execute/memory match on operand A always selects that stage
  assert_mem_priority_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && mem_dst != '0 && mem_dst == ex_src_a) |-> fwd_a == 2'b10);

  // R2: memory/writeback path used when only that stage matches operand B
  assert_wb_forward_R2: assert property (@(posedge clk) disable iff (rst)
    (wb_wr && wb_dst != '0 && wb_dst == ex_src_b &&
     !(mem_wr && mem_dst == ex_src_b)) |-> fwd_b == 2'b01);

  // R4: register 0 is never forwarded
  assert_zero_reg_R4: assert property (@(posedge clk) disable iff (rst)
    (ex_src_a == '0) |-> fwd_a == 2'b00);

  // R8: the three stall outputs move together
  assert_stall_coherent_R8: assert property (@(posedge clk) disable iff (rst)
    (hold_pc == hold_ifid) && (hold_ifid == bubble_idex));

  // R8: only a load can interlock
  assert_nonload_nostall_R8: assert property (@(posedge clk) disable iff (rst)
    !ex_is_load |-> !hold_pc);

  // R7: load into a decode source always interlocks
  assert_load_use_R7: assert property (@(posedge clk) disable iff (rst)
    (ex_is_load && ex_dst != '0 && ex_dst == id_src_b) |-> bubble_idex);
endmodule

// File: tb/test_pipe_hazard_unit.sv
module test_pipe_hazard_unit;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] ex_src_a, ex_src_b, mem_dst, wb_dst, ex_dst, id_src_a, id_src_b;
  logic mem_wr, wb_wr, ex_is_load;
  logic [1:0] fwd_a, fwd_b;
  logic hold_pc, hold_ifid, bubble_idex;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pipe_hazard_unit #(.AW(AW)) i_pipe_hazard_unit (
    .clk(clk), .rst(rst),
    .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
    .mem_dst(mem_dst), .mem_wr(mem_wr),
    .wb_dst(wb_dst), .wb_wr(wb_wr),
    .ex_is_load(ex_is_load), .ex_dst(ex_dst),
    .id_src_a(id_src_a), .id_src_b(id_src_b),
    .fwd_a(fwd_a), .fwd_b(fwd_b),
    .hold_pc(hold_pc), .hold_ifid(hold_ifid), .bubble_idex(bubble_idex)
  );

  function automatic logic [1:0] model_sel(input logic [AW-1:0] s,
      input logic [AW-1:0] md, input logic mw, input logic [AW-1:0] wd, input logic ww);
    if (mw && md != 0 && md == s) return 2'b10;
    if (ww && wd != 0 && wd == s) return 2'b01;
    return 2'b00;
  endfunction

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    ex_src_a = 0; ex_src_b = 0; mem_dst = 0; wb_dst = 0; ex_dst = 0;
    id_src_a = 0; id_src_b = 0; mem_wr = 0; wb_wr = 0; ex_is_load = 0;
  endtask

  task automatic set_fwd(input int a, input int b, input int md, input bit mw,
                         input int wd, input bit ww);
    @(negedge clk);
    idle();
    ex_src_a = a[AW-1:0]; ex_src_b = b[AW-1:0];
    mem_dst = md[AW-1:0]; mem_wr = mw; wb_dst = wd[AW-1:0]; wb_wr = ww;
    #1;
  endtask

  task automatic set_lu(input bit ld, input int d, input int a, input int b);
    @(negedge clk);
    idle();
    ex_is_load = ld; ex_dst = d[AW-1:0]; id_src_a = a[AW-1:0]; id_src_b = b[AW-1:0];
    #1;
  endtask

  task automatic chk_stall(input string req, input bit exp);
    chk(req, {1'b0, hold_pc, hold_ifid, bubble_idex}, {1'b0, exp, exp, exp});
  endtask

  task automatic t_reset();
    chk("R5 reset fwd_a", {2'b0, fwd_a}, 4'h0);
    chk("R5 reset fwd_b", {2'b0, fwd_b}, 4'h0);
    chk_stall("R8 reset stall", 1'b0);
  endtask

  task automatic t_mem_fwd();
    set_fwd(7, 3, 7, 1, 0, 0);
    chk("R1 mem forward A", {2'b0, fwd_a}, 4'h2);
    chk("R6 B untouched", {2'b0, fwd_b}, 4'h0);
    set_fwd(4, 9, 9, 1, 0, 0);
    chk("R1 mem forward B", {2'b0, fwd_b}, 4'h2);
  endtask

  task automatic t_wb_fwd();
    set_fwd(12, 5, 3, 1, 12, 1);
    chk("R2 wb forward A", {2'b0, fwd_a}, 4'h1);
    set_fwd(6, 6, 0, 0, 6, 1);
    chk("R2 wb forward both A", {2'b0, fwd_a}, 4'h1);
    chk("R2 wb forward both B", {2'b0, fwd_b}, 4'h1);
  endtask

  task automatic t_both();
    set_fwd(20, 20, 20, 1, 20, 1);
    chk("R3 priority A", {2'b0, fwd_a}, 4'h2);
    chk("R3 priority B", {2'b0, fwd_b}, 4'h2);
  endtask

  task automatic t_qualify();
    set_fwd(0, 0, 0, 1, 0, 1);
    chk("R4 x0 A", {2'b0, fwd_a}, 4'h0);
    chk("R4 x0 B", {2'b0, fwd_b}, 4'h0);
    set_fwd(11, 2, 11, 0, 11, 1);
    chk("R4 mem wr low falls to wb", {2'b0, fwd_a}, 4'h1);
    set_fwd(11, 2, 11, 0, 11, 0);
    chk("R4 both wr low", {2'b0, fwd_a}, 4'h0);
  endtask

  task automatic t_far();
    set_fwd(8, 9, 10, 1, 13, 1);
    chk("R5 no match A", {2'b0, fwd_a}, 4'h0);
    chk("R5 no match B", {2'b0, fwd_b}, 4'h0);
  endtask

  task automatic t_independent();
    set_fwd(14, 15, 14, 1, 15, 1);
    chk("R6 A from mem", {2'b0, fwd_a}, 4'h2);
    chk("R6 B from wb", {2'b0, fwd_b}, 4'h1);
    for (int i = 0; i < 32; i++) begin
      set_fwd(i, 31 - i, (i * 7) % 32, i[0], (i * 3) % 32, i[1]);
      chk("R6 sweep A", {2'b0, fwd_a},
          {2'b0, model_sel(i[AW-1:0], mem_dst, mem_wr, wb_dst, wb_wr)});
      chk("R6 sweep B", {2'b0, fwd_b},
          {2'b0, model_sel(ex_src_b, mem_dst, mem_wr, wb_dst, wb_wr)});
    end
  endtask

  task automatic t_load_use();
    set_lu(1, 5, 5, 1);
    chk_stall("R7 load-use first field", 1'b1);
    set_lu(1, 17, 2, 17);
    chk_stall("R7 load-use second field", 1'b1);
  endtask

  task automatic t_no_stall();
    set_lu(0, 5, 5, 5);
    chk_stall("R8 non-load match", 1'b0);
    set_lu(1, 0, 0, 0);
    chk_stall("R8 load to x0", 1'b0);
    set_lu(1, 9, 8, 10);
    chk_stall("R8 load no match", 1'b0);
  endtask

  task automatic t_same_cycle();
    set_fwd(3, 0, 3, 1, 0, 0);
    ex_src_a = 4;
    #1;
    chk("R9 same-cycle fwd change", {2'b0, fwd_a}, 4'h0);
    ex_is_load = 1; ex_dst = 4; id_src_a = 4;
    #1;
    chk_stall("R9 same-cycle stall", 1'b1);
  endtask

  initial begin
    idle();
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    t_reset();
    t_mem_fwd();
    t_wb_fwd();
    t_both();
    t_qualify();
    t_far();
    t_independent();
    t_load_use();
    t_no_stall();
    t_same_cycle();
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule